// File: doc/BRIEF.md
# Stereo Converter Serial Control Port

This block is the control port of a stereo audio converter. Three slow pins arrive from a host: a shift clock, a data line and a latch strobe. All three are brought into the system clock domain through a synchronizer. Each rising edge of the shift clock moves one data bit into a shift register, most significant bit first. A rising edge of the latch strobe then commits the word to one of four program registers, chosen by an address field inside the word.

Two of the registers hold a left and a right attenuation code. Each code is double-buffered. A write always updates the channel's staging copy. The active level that drives the output only moves when a load flag is written. Setting the load flag from either channel copies both staged codes into both active levels in the same cycle, so the two channels never change gain apart. The other two registers hold mode fields, and these are presented directly as outputs.

Top module: `audio_ctrl_port`

## Requirements
- R1: While reset is held, both active attenuation outputs read 8'hFF and every mode output reads 0.
- R2: Data is taken on each rising edge of the shift clock, first bit = word bit 15. The word commits on the rising edge of the latch strobe.
- R3: A latch rising edge that follows a count of shift-clock rising edges other than exactly 16 (for example 15 or 17) changes no output. The bit count restarts after every latch edge.
- R4: Word bits 10:9 select the target register (0 = left attenuation, 1 = right attenuation, 2 = mode group A, 3 = mode group B). Bits 15:11 have no effect on any output.
- R5: A write to register 0 or 1 with bit 8 = 0 stores bits 7:0 as that channel's staged code and leaves both active attenuation outputs unchanged.
- R6: A write to register 0 or 1 with bit 8 = 1 stores its code and, in the same cycle, sets the left active output to the left staged code and the right active output to the right staged code. The staged codes used are those that include this write.
- R7: Register 2 maps bit 0 to mute_o, bit 1 to deemph_o, bit 2 to op_en_o, bits 4:3 to word_sel_o and bits 8:5 to out_mode_o.
- R8: Register 3 maps bit 0 to fmt_o, bit 1 to lr_pol_o, bit 2 to att_ctl_o, bits 7:6 to fs_sel_o and bit 8 to zero_det_o. Bits 5:3 are ignored.
- R9: Using the default two-stage synchronizer, a register output takes its new value after the third system clock edge, counting from the first edge that samples the latch strobe high. The two edges before that leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial shift clock (asynchronous) |
| sdata_i | input | 1 | Serial data line (asynchronous) |
| latch_i | input | 1 | Word commit strobe (asynchronous) |
| att_l_o | output | 8 | Active left attenuation code |
| att_r_o | output | 8 | Active right attenuation code |
| mute_o | output | 1 | Soft mute enable |
| deemph_o | output | 1 | De-emphasis enable |
| op_en_o | output | 1 | Converter operation control |
| word_sel_o | output | 2 | Input audio word size select |
| out_mode_o | output | 4 | Output mode select |
| fmt_o | output | 1 | Audio data format select |
| lr_pol_o | output | 1 | Word-clock polarity select |
| att_ctl_o | output | 1 | Attenuator control |
| fs_sel_o | output | 2 | Sampling rate select |
| zero_det_o | output | 1 | Zero detection control |

## Verification
A wrong bit count or a shift register that lost its alignment shows up at the very next latch edge. It appears as a field landing in the wrong bits, or as a write that should have been dropped and was not. A staged code that was corrupted stays hidden until some later load flag copies it to the active outputs. For that reason the reference model follows the staged codes on every clock, and each load is checked against the model, not against the last value seen. Synchronizer latency errors appear as an output that changes one edge early or late after the latch edge.

// File: rtl/ctrl_port_pkg.sv
package ctrl_port_pkg;
  localparam int WORD_W   = 16;
  localparam int ATT_W    = 8;
  localparam int ADDR_W   = 2;
  localparam int ADDR_LSB = 9;
  localparam int KEEP_W   = ADDR_LSB + ADDR_W;  // bits above the address are never stored
  localparam int FIELD_W  = 9;
  localparam int LOAD_BIT = 8;
  localparam int N_CH     = 2;
  localparam int CNT_W    = $clog2(WORD_W + 2);

  localparam logic [ATT_W-1:0] ATT_UNITY = '1;

  typedef enum logic [ADDR_W-1:0] {
    SEL_ATT_L  = 2'd0,
    SEL_ATT_R  = 2'd1,
    SEL_MODE_A = 2'd2,
    SEL_MODE_B = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [3:0] out_mode;
    logic [1:0] word_sel;
    logic       op_en;
    logic       deemph;
    logic       mute;
  } mode_a_t;

  typedef struct packed {
    logic       zero_det;
    logic [1:0] fs_sel;
    logic       att_ctl;
    logic       lr_pol;
    logic       fmt;
  } mode_b_t;
endpackage

// File: rtl/ctrl_sync.sv
module ctrl_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/ctrl_shift.sv
module ctrl_shift
  import ctrl_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_en_i,
  input  logic              bit_i,
  input  logic              commit_i,
  output logic [KEEP_W-1:0] word_o,
  output logic              full_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

  logic [KEEP_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (commit_i) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (shift_en_i) begin
      sr_q <= {sr_q[KEEP_W-2:0], bit_i};
      // saturate one past full so any overrun stays invalid
      if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign word_o = sr_q;
  assign full_o = (cnt_q == CNT_FULL);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/ctrl_regs.sv
module ctrl_regs
  import ctrl_port_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  reg_sel_e                    wr_sel_i,
  input  logic [FIELD_W-1:0]          wr_data_i,
  output logic [N_CH-1:0][ATT_W-1:0]  att_o,
  output mode_a_t                     mode_a_o,
  output mode_b_t                     mode_b_o
);
  logic load_all;
  assign load_all = wr_en_i && wr_data_i[LOAD_BIT] &&
                    (wr_sel_i == SEL_ATT_L || wr_sel_i == SEL_ATT_R);

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    logic [ATT_W-1:0] stage_q, act_q, stage_d;
    logic             hit;

    assign hit     = wr_en_i && (wr_sel_i == reg_sel_e'(ch));
    assign stage_d = hit ? wr_data_i[ATT_W-1:0] : stage_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q <= ATT_UNITY;
        act_q   <= ATT_UNITY;
      end else begin
        stage_q <= stage_d;
        if (load_all) act_q <= stage_d;  // both channels move together
      end
    end

    assign att_o[ch] = act_q;
  end

  mode_a_t mode_a_q;
  mode_b_t mode_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_a_q <= '0;
      mode_b_q <= '0;
    end else if (wr_en_i) begin
      if (wr_sel_i == SEL_MODE_A) mode_a_q <= mode_a_t'(wr_data_i);
      if (wr_sel_i == SEL_MODE_B) begin
        mode_b_q.zero_det <= wr_data_i[8];
        mode_b_q.fs_sel   <= wr_data_i[7:6];
        mode_b_q.att_ctl  <= wr_data_i[2];
        mode_b_q.lr_pol   <= wr_data_i[1];
        mode_b_q.fmt      <= wr_data_i[0];
      end
    end
  end

  assign mode_a_o = mode_a_q;
  assign mode_b_o = mode_b_q;
endmodule

// File: rtl/audio_ctrl_port.sv
module audio_ctrl_port
  import ctrl_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             sdata_i,
  input  logic             latch_i,
  output logic [ATT_W-1:0] att_l_o,
  output logic [ATT_W-1:0] att_r_o,
  output logic             mute_o,
  output logic             deemph_o,
  output logic             op_en_o,
  output logic [1:0]       word_sel_o,
  output logic [3:0]       out_mode_o,
  output logic             fmt_o,
  output logic             lr_pol_o,
  output logic             att_ctl_o,
  output logic [1:0]       fs_sel_o,
  output logic             zero_det_o
);
  logic [2:0]               pin_s;
  logic [1:0]               prev_q;
  logic                     sclk_rise, latch_rise;
  logic [KEEP_W-1:0]        word;
  logic                     full;
  logic [CNT_W-1:0]         bit_cnt;
  logic                     wr_en;
  reg_sel_e                 wr_addr;
  logic [FIELD_W-1:0]       wr_data;
  logic [N_CH-1:0][ATT_W-1:0] att;
  mode_a_t                  mode_a;
  mode_b_t                  mode_b;

  ctrl_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({latch_i, sclk_i, sdata_i}),
    .q_o   (pin_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= pin_s[2:1];
  end

  assign sclk_rise  = pin_s[1] & ~prev_q[0];
  assign latch_rise = pin_s[2] & ~prev_q[1];

  ctrl_shift u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_en_i(sclk_rise),
    .bit_i     (pin_s[0]),
    .commit_i  (latch_rise),
    .word_o    (word),
    .full_o    (full),
    .cnt_o     (bit_cnt)
  );

  assign wr_en   = latch_rise & full;
  assign wr_addr = reg_sel_e'(word[KEEP_W-1:ADDR_LSB]);
  assign wr_data = word[FIELD_W-1:0];

  ctrl_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_sel_i (wr_addr),
    .wr_data_i(wr_data),
    .att_o    (att),
    .mode_a_o (mode_a),
    .mode_b_o (mode_b)
  );

  assign att_l_o    = att[0];
  assign att_r_o    = att[1];
  assign mute_o     = mode_a.mute;
  assign deemph_o   = mode_a.deemph;
  assign op_en_o    = mode_a.op_en;
  assign word_sel_o = mode_a.word_sel;
  assign out_mode_o = mode_a.out_mode;
  assign fmt_o      = mode_b.fmt;
  assign lr_pol_o   = mode_b.lr_pol;
  assign att_ctl_o  = mode_b.att_ctl;
  assign fs_sel_o   = mode_b.fs_sel;
  assign zero_det_o = mode_b.zero_det;
endmodule

// File: rtl/ctrl_port_chk.sv
module ctrl_port_chk
  import ctrl_port_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ATT_W-1:0]   att_l_o,
  input logic [ATT_W-1:0]   att_r_o,
  input logic               mute_o,
  input logic [3:0]         out_mode_o,
  input logic               fmt_o,
  input logic               zero_det_o,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [FIELD_W-1:0] wr_data,
  input logic [CNT_W-1:0]   bit_cnt
);
  AST_ATT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en && wr_addr[1] == 1'b0 && wr_data[LOAD_BIT]) |=> ($stable(att_l_o) && $stable(att_r_o))); // R5

  AST_LOAD_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && wr_addr == 2'd0 && wr_data[LOAD_BIT]) |=> att_l_o == $past(wr_data[ATT_W-1:0])); // R6

  AST_LOAD_RIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && wr_addr == 2'd1 && wr_data[LOAD_BIT]) |=> att_r_o == $past(wr_data[ATT_W-1:0])); // R6

  AST_MODE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> ($stable(mute_o) && $stable(out_mode_o) && $stable(fmt_o) && $stable(zero_det_o))); // R3

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt <= CNT_W'(WORD_W + 1)); // R3

  AST_MODE_A_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && wr_addr == 2'd2) |=> (mute_o == $past(wr_data[0]) && out_mode_o == $past(wr_data[8:5]))); // R7

  AST_MODE_B_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && wr_addr == 2'd3) |=> (fmt_o == $past(wr_data[0]) && zero_det_o == $past(wr_data[8]))); // R8
endmodule

bind audio_ctrl_port ctrl_port_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .att_l_o   (att_l_o),
  .att_r_o   (att_r_o),
  .mute_o    (mute_o),
  .out_mode_o(out_mode_o),
  .fmt_o     (fmt_o),
  .zero_det_o(zero_det_o),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .bit_cnt   (bit_cnt)
);

// File: tb/audio_ctrl_port_test.sv
`timescale 1ns/1ps
module audio_ctrl_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 3;
  localparam int WATCHDOG   = 50000;

  logic clk = 0, rst_n = 0;
  logic sclk = 0, sdata = 0, latch = 0;
  logic [7:0] att_l, att_r;
  logic mute, deemph, op_en, fmt, lr_pol, att_ctl, zero_det;
  logic [1:0] word_sel, fs_sel;
  logic [3:0] out_mode;

  int n_chk = 0, n_fail = 0;
  bit running = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_ctrl_port uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdata), .latch_i(latch),
    .att_l_o(att_l), .att_r_o(att_r), .mute_o(mute), .deemph_o(deemph), .op_en_o(op_en),
    .word_sel_o(word_sel), .out_mode_o(out_mode), .fmt_o(fmt), .lr_pol_o(lr_pol),
    .att_ctl_o(att_ctl), .fs_sel_o(fs_sel), .zero_det_o(zero_det)
  );

  task automatic chk(input string tag, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s got %0h exp %0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [2:0] hq[$] = '{3'b000, 3'b000, 3'b000};
  int         m_cnt;
  logic [15:0] m_word;
  logic [7:0]  m_st_l, m_st_r, m_att_l, m_att_r;
  logic [8:0]  m_a;
  logic [5:0]  m_b;  // {zero_det, fs_sel, att_ctl, lr_pol, fmt}

  task automatic apply_word(input logic [15:0] w);
    case (w[10:9])
      2'd0: begin m_st_l = w[7:0]; if (w[8]) begin m_att_l = m_st_l; m_att_r = m_st_r; end end
      2'd1: begin m_st_r = w[7:0]; if (w[8]) begin m_att_l = m_st_l; m_att_r = m_st_r; end end
      2'd2: m_a = w[8:0];
      default: m_b = {w[8], w[7:6], w[2], w[1], w[0]};
    endcase
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hq = '{3'b000, 3'b000, 3'b000};
      m_cnt = 0; m_word = '0;
      m_st_l = 8'hFF; m_st_r = 8'hFF; m_att_l = 8'hFF; m_att_r = 8'hFF;
      m_a = '0; m_b = '0;
    end else begin
      if (hq[1][2] && !hq[2][2]) begin
        if (m_cnt == 16) apply_word(m_word);
        m_cnt = 0; m_word = '0;
      end else if (hq[1][1] && !hq[2][1]) begin
        m_word = {m_word[14:0], hq[1][0]};
        m_cnt++;
      end
      hq.push_front({latch, sclk, sdata});
      void'(hq.pop_back());
    end
  end

  always @(negedge clk) begin
    if (running && rst_n) begin
      chk("R6", "model att_l", att_l, m_att_l);
      chk("R6", "model att_r", att_r, m_att_r);
      chk("R7", "model mode A", {out_mode, word_sel, op_en, deemph, mute}, m_a);
      chk("R8", "model mode B", {zero_det, fs_sel, att_ctl, lr_pol, fmt}, m_b);
    end
  end

  task automatic shift_bits(input logic [16:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = w[i];
      repeat (HOLD) @(negedge clk);
      sclk = 1;
      repeat (HOLD) @(negedge clk);
      sclk = 0;
    end
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic send(input logic [16:0] w, input int n);
    shift_bits(w, n);
    latch = 1;
    repeat (HOLD) @(negedge clk);
    latch = 0;
    repeat (HOLD + 2) @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset att_l", att_l, 8'hFF);
    chk("R1", "reset att_r", att_r, 8'hFF);
    chk("R1", "reset mode A", {out_mode, word_sel, op_en, deemph, mute}, 0);
    chk("R1", "reset mode B", {zero_det, fs_sel, att_ctl, lr_pol, fmt}, 0);
    rst_n = 1;
    running = 1;
    @(negedge clk);

    // R5: left code staged without load
    send(17'h00040, 16);
    chk("R5", "att_l after unloaded write", att_l, 8'hFF);
    chk("R5", "att_r after unloaded write", att_r, 8'hFF);

    // R6: right write with load moves both channels
    send(17'h00310, 16);
    chk("R6", "att_l after right load", att_l, 8'h40);
    chk("R6", "att_r after right load", att_r, 8'h10);

    // R4, R7, R2: mode A with reserved top bits set
    send(17'h0FDA5, 16);
    chk("R7", "out_mode", out_mode, 4'hD);
    chk("R7", "word_sel", word_sel, 2'b00);
    chk("R7", "op_en", op_en, 1);
    chk("R7", "deemph", deemph, 0);
    chk("R2", "mute msb-first", mute, 1);
    chk("R4", "reserved bits leave att_l", att_l, 8'h40);

    // R8: mode B, bits 5:3 set but ignored
    send(17'h007FF, 16);
    chk("R8", "mode B fields", {zero_det, fs_sel, att_ctl, lr_pol, fmt}, 6'h3F);
    chk("R8", "mode A untouched", {out_mode, word_sel, op_en, deemph, mute}, 9'h1A5);

    // R3: short and long words are dropped
    send(17'h00400, 15);
    chk("R3", "15-bit word dropped", {out_mode, word_sel, op_en, deemph, mute}, 9'h1A5);
    send(17'h10400, 17);
    chk("R3", "17-bit word dropped", {out_mode, word_sel, op_en, deemph, mute}, 9'h1A5);
    send(17'h00500, 16);
    chk("R3", "count restarts after drop", {out_mode, word_sel, op_en, deemph, mute}, 9'h100);

    // R5 then R6: staged right code taken up by a left load
    send(17'h00222, 16);
    chk("R5", "att_r holds with unloaded write", att_r, 8'h10);
    send(17'h001AA, 16);
    chk("R6", "att_l after left load", att_l, 8'hAA);
    chk("R6", "att_r picks staged code", att_r, 8'h22);

    // R4: address 0 with all reserved bits set
    send(17'h0F900, 16);
    chk("R4", "att_l with reserved bits", att_l, 8'h00);
    chk("R4", "att_r with reserved bits", att_r, 8'h22);

    // R9: latency from latch edge to output
    shift_bits(17'h00401, 16);
    latch = 1;
    @(negedge clk);
    chk("R9", "mute one edge after latch", mute, 0);
    @(negedge clk);
    chk("R9", "mute two edges after latch", mute, 0);
    @(negedge clk);
    chk("R9", "mute three edges after latch", mute, 1);
    repeat (HOLD) @(negedge clk);
    latch = 0;
    repeat (HOLD + 2) @(negedge clk);

    running = 0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule